// File: doc/BRIEF.md
# NVM Image Checksum Engine

This block walks a non-volatile memory image through a word-wide read/write port and either checks or repairs its integrity word. The integrity rule is a plain modulo-65536 sum of 16-bit words: adding every word from index 0 up to and including the checksum word must give a fixed target value (0xBABA by default). It is not a CRC and not an XOR.

A check command reads words 0 through the checksum index one at a time and reports whether the sum hit the target. A repair command reads the words below the checksum index, then writes the value that makes the full sum hit the target (target minus partial sum, modulo 2^16) into the checksum location. A read or write fault on the memory port ends the operation at once with an error. The accumulated sum stays visible on a status port after the operation.

Each read is a request held until the port returns either data or a fault. A write works the same way with an acknowledge or a fault. The checksum index and the target are parameters.

Top module: `nvm_csum_engine`

## Requirements
- R1: A check reads addresses 0, 1, ..., CHK_IDX in ascending order, one request at a time. Each request (rd_req_o with rd_addr_o) is held unchanged until rd_valid_i or rd_err_i, and no address above CHK_IDX is requested.
- R2: After a check without a fault, pass_o=1 and error_o=0 when the modulo-2^16 sum of the words read equals TARGET. Otherwise pass_o=0 and error_o=0. sum_o shows that sum.
- R3: A repair reads addresses 0..CHK_IDX-1 only. It then issues exactly one write to address CHK_IDX with data TARGET minus the partial sum (mod 2^16). On wr_ack_i it ends with pass_o=1 and error_o=0, and sum_o shows the partial sum.
- R4: rd_err_i while a read is requested aborts the operation. No further read or write is issued, and the operation ends with error_o=1 and pass_o=0.
- R5: wr_err_i on the repair write ends the operation with error_o=1 and pass_o=0.
- R6: done_o pulses high for exactly one cycle, in the cycle after the final port response. busy_o is high from the cycle after a command is accepted until that cycle, and is low while done_o is high.
- R7: validate_i or update_i asserted while busy_o is high has no effect on the running operation, its port traffic or its results.
- R8: When validate_i and update_i are both high in an idle cycle, a check is started and no write is issued.
- R9: rd_req_o and wr_req_o are never high together. After reset, busy_o, done_o, pass_o, error_o, rd_req_o and wr_req_o are 0 and sum_o is 0.
- R10: pass_o, error_o and sum_o hold their final values until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| validate_i | input | 1 | Start a check (wins over update_i) |
| update_i | input | 1 | Start a repair of the checksum word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed successfully |
| error_o | output | 1 | Operation aborted by a port fault |
| sum_o | output | DATA_W | Accumulated word sum |
| rd_req_o | output | 1 | Read request, held until response |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_valid_i | input | 1 | Read data returned |
| rd_err_i | input | 1 | Read fault |
| rd_data_i | input | DATA_W | Read data |
| wr_req_o | output | 1 | Write request, held until response |
| wr_addr_o | output | ADDR_W | Write word address |
| wr_data_o | output | DATA_W | Write data |
| wr_ack_i | input | 1 | Write accepted |
| wr_err_i | input | 1 | Write fault |

## Verification
The bench builds the engine with its default parameters: a 64-word span with the checksum word at index 0x3F and a target of 0xBABA. With the full span every run crosses the complete address range, so ordering and the last-address decision for both commands (63 versus 62) are exercised. Random port latency of zero to two cycles stresses the request-hold rule. Random images, half of them forced to sum to the target, cover both pass and mismatch. Directed faults at chosen read addresses and on the repair write cover the abort paths.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} st_e;
  typedef enum logic {OP_CHECK, OP_FIX} op_e;
endpackage

// File: rtl/nvm_csum_addr_seq.sv
module nvm_csum_addr_seq #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned CHK_IDX = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              fix_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] CHK_A = ADDR_W'(CHK_IDX);
  localparam logic [ADDR_W-1:0] PRE_A = (CHK_IDX == 0) ? '0 : ADDR_W'(CHK_IDX - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clr_i)   addr_q <= '0;
    else if (step_i)  addr_q <= addr_q + 1'b1;
  end

  // repair stops one word short of the checksum slot
  assign last_o = fix_i ? (addr_q == PRE_A) : (addr_q == CHK_A);
  assign addr_o = addr_q;
endmodule

// File: rtl/nvm_csum_acc.sv
module nvm_csum_acc #(
  parameter int unsigned        DATA_W = 16,
  parameter logic [DATA_W-1:0]  TARGET = 16'hBABA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              hit_next_o,
  output logic [DATA_W-1:0] fix_o
);
  logic [DATA_W-1:0] sum_q, sum_nx;

  assign sum_nx = sum_q + data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_nx;
  end

  assign sum_o      = sum_q;
  assign hit_next_o = (sum_nx == TARGET);
  assign fix_o      = TARGET - sum_q;
endmodule

// File: rtl/nvm_csum_ctrl.sv
module nvm_csum_ctrl
  import nvm_csum_pkg::*;
#(
  parameter bit NO_PRE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic validate_i,
  input  logic update_i,
  input  logic rd_valid_i,
  input  logic rd_err_i,
  input  logic wr_ack_i,
  input  logic wr_err_i,
  input  logic last_i,
  input  logic hit_next_i,
  output logic rd_req_o,
  output logic wr_req_o,
  output logic clr_o,
  output logic add_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o,
  output logic pass_o,
  output logic error_o
);
  st_e  st_q, st_d;
  op_e  op_q, op_d;
  logic done_q, done_d, pass_q, pass_d, err_q, err_d;
  logic start, rd_ok;

  assign start = (st_q == ST_IDLE) && (validate_i || update_i);
  assign rd_ok = (st_q == ST_READ) && rd_valid_i && !rd_err_i;

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    done_d = 1'b0;
    pass_d = pass_q;
    err_d  = err_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        op_d   = validate_i ? OP_CHECK : OP_FIX;
        pass_d = 1'b0;
        err_d  = 1'b0;
        st_d   = (!validate_i && NO_PRE) ? ST_WRITE : ST_READ;
      end
      ST_READ: begin
        if (rd_err_i) begin
          st_d = ST_IDLE; done_d = 1'b1; err_d = 1'b1;
        end else if (rd_valid_i && last_i) begin
          if (op_q == OP_CHECK) begin
            st_d = ST_IDLE; done_d = 1'b1; pass_d = hit_next_i;
          end else begin
            st_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (wr_err_i) begin
          st_d = ST_IDLE; done_d = 1'b1; err_d = 1'b1;
        end else if (wr_ack_i) begin
          st_d = ST_IDLE; done_d = 1'b1; pass_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_CHECK;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      done_q <= done_d;
      pass_q <= pass_d;
      err_q  <= err_d;
    end
  end

  assign rd_req_o = (st_q == ST_READ);
  assign wr_req_o = (st_q == ST_WRITE);
  assign clr_o    = start;
  assign add_o    = rd_ok;
  assign step_o   = rd_ok && !last_i;
  assign fix_o    = (op_q == OP_FIX);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign pass_o   = pass_q;
  assign error_o  = err_q;

  // R9
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R2
  pass_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && error_o));
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !validate_i && !update_i) |=> ($stable(pass_o) && $stable(error_o)));
endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine
  import nvm_csum_pkg::*;
#(
  parameter int unsigned       DATA_W  = 16,
  parameter int unsigned       ADDR_W  = 6,
  parameter int unsigned       CHK_IDX = 63,
  parameter logic [DATA_W-1:0] TARGET  = 16'hBABA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              validate_i,
  input  logic              update_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              error_o,
  output logic [DATA_W-1:0] sum_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic              rd_err_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  input  logic              wr_err_i
);
  localparam bit                NO_PRE = (CHK_IDX == 0);
  localparam logic [ADDR_W-1:0] CHK_A  = ADDR_W'(CHK_IDX);

  logic clr, add, step, fix, last, hit_next;

  nvm_csum_ctrl #(.NO_PRE(NO_PRE)) u_ctrl (
    .clk_i, .rst_ni, .validate_i, .update_i,
    .rd_valid_i, .rd_err_i, .wr_ack_i, .wr_err_i,
    .last_i(last), .hit_next_i(hit_next),
    .rd_req_o, .wr_req_o,
    .clr_o(clr), .add_o(add), .step_o(step), .fix_o(fix),
    .busy_o, .done_o, .pass_o, .error_o
  );

  nvm_csum_addr_seq #(.ADDR_W(ADDR_W), .CHK_IDX(CHK_IDX)) u_seq (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step), .fix_i(fix),
    .addr_o(rd_addr_o), .last_o(last)
  );

  nvm_csum_acc #(.DATA_W(DATA_W), .TARGET(TARGET)) u_acc (
    .clk_i, .rst_ni, .clr_i(clr), .add_i(add), .data_i(rd_data_i),
    .sum_o, .hit_next_o(hit_next), .fix_o(wr_data_o)
  );

  assign wr_addr_o = CHK_A;

  // R1
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i && !rd_err_i) |=> (rd_req_o && $stable(rd_addr_o)));
  // R1
  rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o <= CHK_A));
  // R3
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i && !wr_err_i) |=> (wr_req_o && $stable(wr_data_o)));
  // R4
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_err_i) |=> (!rd_req_o && !wr_req_o));
endmodule

// File: tb/sim_nvm_csum_engine.sv
`timescale 1ns/1ps
module sim_nvm_csum_engine;
  localparam int          CHK = 63;
  localparam logic [15:0] TGT = 16'hBABA;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic validate_i = 1'b0, update_i = 1'b0;
  logic busy_o, done_o, pass_o, error_o;
  logic [15:0] sum_o;
  logic rd_req_o, rd_valid_i, rd_err_i;
  logic [5:0] rd_addr_o, wr_addr_o;
  logic [15:0] rd_data_i, wr_data_o;
  logic wr_req_o, wr_ack_i, wr_err_i;

  always #10 clk = ~clk;

  nvm_csum_engine u0 (
    .clk_i(clk), .rst_ni, .validate_i, .update_i,
    .busy_o, .done_o, .pass_o, .error_o, .sum_o,
    .rd_req_o, .rd_addr_o, .rd_valid_i, .rd_err_i, .rd_data_i,
    .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ack_i, .wr_err_i
  );

  logic [15:0] mem [0:63];
  int n_chk = 0, n_fail = 0;
  int n_reads, n_writes, addr_bad, exp_addr, err_at = -1, lat;
  bit wr_fail = 1'b0;
  logic [5:0]  last_wa;
  logic [15:0] last_wd;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(input int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  // memory port responder
  initial begin
    rd_valid_i = 0; rd_err_i = 0; rd_data_i = '0; wr_ack_i = 0; wr_err_i = 0;
    forever begin
      @(negedge clk);
      rd_valid_i = 0; rd_err_i = 0; wr_ack_i = 0; wr_err_i = 0;
      if (rd_req_o) begin
        lat = $urandom % 3;
        repeat (lat) @(negedge clk);
        n_reads++;
        if (int'(rd_addr_o) != exp_addr) addr_bad++;
        exp_addr++;
        if (int'(rd_addr_o) == err_at) rd_err_i = 1;
        else begin rd_valid_i = 1; rd_data_i = mem[rd_addr_o]; end
      end else if (wr_req_o) begin
        lat = $urandom % 3;
        repeat (lat) @(negedge clk);
        n_writes++;
        last_wa = wr_addr_o; last_wd = wr_data_o;
        if (wr_fail) wr_err_i = 1;
        else begin wr_ack_i = 1; mem[wr_addr_o] = wr_data_o; end
      end
    end
  end

  // v/u: command inputs; poke>0 pulses update_i that many cycles into the run
  task automatic run_op(input bit v, input bit u, input int poke);
    int cyc = 0;
    n_reads = 0; n_writes = 0; addr_bad = 0; exp_addr = 0;
    @(negedge clk);
    validate_i = v; update_i = u;
    @(negedge clk);
    validate_i = 0; update_i = 0;
    chk(busy_o == 1'b1, "R6", "busy after accept", busy_o, 1);
    while (!done_o && cyc < 4000) begin
      @(negedge clk);
      update_i = (poke != 0 && cyc == poke);
      cyc++;
    end
    update_i = 0;
    chk(done_o == 1'b1, "R6", "done reached", done_o, 1);
    chk(busy_o == 1'b0, "R6", "busy low at done", busy_o, 0);
    chk(addr_bad == 0, "R1", "read order", addr_bad, 0);
  endtask

  task automatic post_done;
    @(negedge clk);
    chk(done_o == 1'b0, "R6", "done single cycle", done_o, 0);
  endtask

  task automatic fill_random(input bit make_pass);
    for (int i = 0; i <= CHK; i++) mem[i] = 16'($urandom);
    if (make_pass) mem[CHK] = TGT - sum_to(CHK - 1);
  endtask

  initial begin
    logic [15:0] exp_s;
    logic [15:0] p, s;
    bit pass_e;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({busy_o, done_o, pass_o, error_o, rd_req_o, wr_req_o} == 6'b0, "R9",
        "reset outputs", {busy_o, done_o, pass_o, error_o, rd_req_o, wr_req_o}, 0);
    chk(sum_o == 16'h0, "R9", "reset sum", sum_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R3 repair
    fill_random(1'b0);
    exp_s = sum_to(CHK - 1);
    run_op(0, 1, 0);
    chk(n_reads == CHK, "R3", "repair reads", n_reads, CHK);
    chk(n_writes == 1, "R3", "repair writes", n_writes, 1);
    chk(last_wa == 6'(CHK), "R3", "write addr", last_wa, CHK);
    chk(last_wd == TGT - exp_s, "R3", "write data", last_wd, TGT - exp_s);
    chk(sum_o == exp_s, "R3", "partial sum", sum_o, exp_s);
    chk(pass_o && !error_o, "R3", "pass/err", {pass_o, error_o}, 2);
    post_done();

    // R2 check passes after repair
    run_op(1, 0, 0);
    chk(n_reads == CHK + 1, "R1", "check reads", n_reads, CHK + 1);
    chk(n_writes == 0, "R2", "check writes", n_writes, 0);
    chk(sum_o == TGT, "R2", "sum", sum_o, TGT);
    chk(pass_o && !error_o, "R2", "pass", {pass_o, error_o}, 2);
    post_done();

    // R2 mismatch
    mem[10] = mem[10] ^ 16'h0001;
    exp_s = sum_to(CHK);
    run_op(1, 0, 0);
    chk(sum_o == exp_s, "R2", "mismatch sum", sum_o, exp_s);
    chk(!pass_o && !error_o, "R2", "mismatch flags", {pass_o, error_o}, 0);
    // R10 hold
    repeat (5) @(negedge clk);
    chk(sum_o == exp_s && !pass_o && !error_o, "R10", "hold", sum_o, exp_s);

    // R4 read fault during check
    err_at = 20;
    run_op(1, 0, 0);
    chk(n_reads == 21, "R4", "reads before abort", n_reads, 21);
    chk(n_writes == 0, "R4", "no write", n_writes, 0);
    chk(error_o && !pass_o, "R4", "err flags", {pass_o, error_o}, 1);
    // R4 read fault during repair
    err_at = 5;
    p = mem[CHK];
    run_op(0, 1, 0);
    chk(n_reads == 6, "R4", "repair abort reads", n_reads, 6);
    chk(n_writes == 0 && mem[CHK] == p, "R4", "repair no write", n_writes, 0);
    chk(error_o && !pass_o, "R4", "repair err flags", {pass_o, error_o}, 1);
    err_at = -1;

    // R5 write fault
    wr_fail = 1'b1;
    run_op(0, 1, 0);
    chk(n_writes == 1, "R5", "write attempted", n_writes, 1);
    chk(error_o && !pass_o, "R5", "write err flags", {pass_o, error_o}, 1);
    wr_fail = 1'b0;

    // R7 command while busy ignored
    fill_random(1'b1);
    run_op(1, 0, 5);
    chk(n_writes == 0, "R7", "no write from poke", n_writes, 0);
    chk(n_reads == CHK + 1, "R7", "reads", n_reads, CHK + 1);
    chk(pass_o && sum_o == TGT, "R7", "result", sum_o, TGT);
    repeat (3) @(negedge clk);
    chk(!busy_o, "R7", "no restart", busy_o, 0);

    // R8 both commands: check wins
    run_op(1, 1, 0);
    chk(n_writes == 0 && n_reads == CHK + 1, "R8", "priority", n_writes, 0);

    // random images and commands
    for (int it = 0; it < 12; it++) begin
      bit op;
      fill_random(it % 2 == 0);
      op = 1'($urandom % 2);
      if (op) begin
        s = sum_to(CHK - 1);
        run_op(0, 1, 0);
        chk(last_wd == TGT - s && n_writes == 1, "R3", "rand write", last_wd, TGT - s);
        chk(sum_o == s && pass_o, "R3", "rand sum", sum_o, s);
      end else begin
        s = sum_to(CHK);
        pass_e = (s == TGT);
        run_op(1, 0, 0);
        chk(sum_o == s, "R2", "rand sum", sum_o, s);
        chk(pass_o == pass_e && !error_o, "R2", "rand pass", pass_o, pass_e);
      end
      post_done();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule